// File: doc/BRIEF.md
# DMA Channel Parameter and Status Engine

This block is the control core of a single DMA channel. It keeps the current source address, the current destination address and a block-length counter, plus a shadow set (next source, next destination, next length) that software fills while a block is running. Each accepted transfer strobe moves both addresses by their own programmed step and counts the block down by one. When the count runs out, the engine either loads the shadow set (double-buffered mode, only when the parameters-valid flag is set) or always loads it (auto-initialize mode). Data movement and bus arbitration live elsewhere: a mover raises `xfer_strobe` once per completed beat.

A byte-wide status word carries four flags: terminal count (bit 0), overrun (bit 1), channel active (bit 2, read-only, equal to enable AND count non-zero) and parameters valid (bit 3). Bits 7..4 read as zero. Terminal count, overrun and parameters valid are sticky and cleared by writing 1 to their positions. Single-buffer use is double-buffered mode with the shadow length never rewritten, so overrun then rises with every terminal count.

A two-state sequencer drives the counters. IDLE means the count is zero. RUN means a block is in progress. Transitions: START (IDLE to RUN, enable and valid set, shadow copied); STEP (RUN to RUN, strobe with count above one); RELOAD (RUN to RUN, last strobe with a copy of a non-zero shadow length); FINISH (RUN to IDLE, last strobe with no copy, or a copy of a zero length). Register selects: 0 control ([0] enable, [1] auto-initialize, [3:2] source step, [5:4] destination step), 1 next source, 2 next destination, 3 next length, 4 status, 5 current source, 6 current destination, 7 current count. Selects 5..7 are read-only. Reads are combinational.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the status word, the current addresses, the current count, the shadow set and the control register all read zero, and `chan_active` is low.
- R2: A step code of 00 adds 1, 01 adds 2, 10 subtracts 1 and 11 subtracts 2 to its address on each accepted strobe, modulo 2^W, independently for source (control [3:2]) and destination (control [5:4]).
- R3: A strobe is accepted only when enable is set and the count is non-zero. Each accepted strobe lowers the count by one, and ignored strobes change no current register.
- R4: Status bit 2 and `chan_active` always equal enable AND (count != 0), and writes to status bit 2 have no effect.
- R5: The strobe that takes the count from 1 to 0 sets terminal count (status bit 0) at the same clock edge.
- R6: Writing 1 to status bit 0, 1 or 3 clears that flag, writing 0 leaves it unchanged, and bits 7..4 always read 0.
- R7: Writing the next-length register (select 3) sets parameters valid (status bit 3).
- R8: In IDLE with enable set, the edge after parameters valid is set copies the shadow set into the current registers and clears parameters valid (START). Without parameters valid the channel stays in IDLE.
- R9: In double-buffered mode (control [1] = 0), the last strobe of a block copies the shadow set and clears parameters valid if it was set. If it was clear, overrun (status bit 1) is set and the channel goes to IDLE with addresses stepped.
- R10: In auto-initialize mode (control [1] = 1), the last strobe always copies the shadow set and the channel stays active. Overrun is set only if terminal count was already set before that strobe.
- R11: When a write-one-to-clear and a hardware set of the same flag fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | W | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | W | Combinational read data |
| xfer_strobe | input | 1 | One completed transfer beat |
| chan_active | output | 1 | Enable AND count non-zero |
| blk_done | output | 1 | High while an accepted strobe ends a block |

## Verification
The main sweep covers every start address at an 8-bit width against all sixteen source/destination step-code pairs. Starting near both ends of the range separates correct modulo wrap from saturation and catches swapped or mis-signed step codes. Directed sequences then run each mode through completion with parameters valid set and with it clear, and with terminal count left set and with it cleared. These runs show whether reload, overrun and the sticky flags follow the mode. One run puts a clear and a set of the same flag in the same cycle, and another strobes while the channel is disabled, to show that the set wins and that ignored beats leave the counters alone.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        STEP_INC1 = 2'b00,
        STEP_INC2 = 2'b01,
        STEP_DEC1 = 2'b10,
        STEP_DEC2 = 2'b11
    } step_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_SRC_NEXT = 3'd1,
        SEL_DST_NEXT = 3'd2,
        SEL_LEN_NEXT = 3'd3,
        SEL_STATUS   = 3'd4,
        SEL_SRC_CUR  = 3'd5,
        SEL_DST_CUR  = 3'd6,
        SEL_LEN_CUR  = 3'd7
    } reg_sel_e;

    localparam int CTRL_W    = 6;
    localparam int STATUS_W  = 8;
    localparam int FLAG_N    = 3;   // sticky flags: 0 tc, 1 ovr, 2 vld
    localparam int BIT_TC    = 0;
    localparam int BIT_OVR   = 1;
    localparam int BIT_CHAC  = 2;
    localparam int BIT_VLD   = 3;

endpackage

// File: rtl/dma_step_unit.sv
module dma_step_unit
    import dma_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  step_code_e   code,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    always_comb begin
        unique case (code)
            STEP_INC1: nxt = cur + ONE;
            STEP_INC2: nxt = cur + TWO;
            STEP_DEC1: nxt = cur - ONE;
            STEP_DEC2: nxt = cur - TWO;
        endcase
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         auto_mode,
    input  logic         xfer_strobe,
    input  logic         vld_q,
    input  step_code_e   src_step,
    input  step_code_e   dst_step,
    input  logic [W-1:0] nxt_src,
    input  logic [W-1:0] nxt_dst,
    input  logic [W-1:0] nxt_len,
    output logic [W-1:0] cur_src,
    output logic [W-1:0] cur_dst,
    output logic [W-1:0] cur_len,
    output logic         blk_done,
    output logic         param_copy,
    output logic         chan_active
);
    localparam int PORTS = 2;   // 0 source, 1 destination

    chan_state_e             state_q, state_d;
    logic [PORTS-1:0][W-1:0] addr_q, addr_d, step_out;
    logic [PORTS-1:0][1:0]   code_v;
    logic [W-1:0]            len_q, len_d;
    logic                    accept, last;

    assign code_v[0] = src_step;
    assign code_v[1] = dst_step;

    for (genvar g = 0; g < PORTS; g++) begin : g_step
        dma_step_unit #(.W(W)) u_step (
            .cur  (addr_q[g]),
            .code (step_code_e'(code_v[g])),
            .nxt  (step_out[g])
        );
    end

    assign accept = xfer_strobe && enable && (state_q == ST_RUN);
    assign last   = accept && (len_q == W'(1));

    // next-state and copy decision
    always_comb begin
        state_d    = state_q;
        param_copy = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && vld_q) begin          // START
                    param_copy = 1'b1;
                    state_d    = (nxt_len != '0) ? ST_RUN : ST_IDLE;
                end
            end
            ST_RUN: begin
                if (last) begin
                    if (auto_mode || vld_q) begin   // RELOAD
                        param_copy = 1'b1;
                        state_d    = (nxt_len != '0) ? ST_RUN : ST_IDLE;
                    end else begin                  // FINISH
                        state_d    = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath outputs
    always_comb begin
        addr_d = addr_q;
        len_d  = len_q;
        if (param_copy) begin
            addr_d[0] = nxt_src;
            addr_d[1] = nxt_dst;
            len_d     = nxt_len;
        end else if (accept) begin
            addr_d = step_out;
            len_d  = len_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            addr_q <= addr_d;
            len_q  <= len_d;
        end
    end

    assign cur_src     = addr_q[0];
    assign cur_dst     = addr_q[1];
    assign cur_len     = len_q;
    assign blk_done    = last;
    assign chan_active = enable && (len_q != '0);

    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !param_copy) |=> (len_q == $past(len_q) - W'(1)));

    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && state_q == ST_RUN) |=> ($stable(len_q) && $stable(addr_q)));

    p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) == (len_q != '0));

    p_start_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && enable && vld_q) |=>
            (len_q == $past(nxt_len) && addr_q[0] == $past(nxt_src)));

    p_dbl_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !auto_mode && vld_q) |=> (len_q == $past(nxt_len)));

    p_auto_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last && auto_mode) |=> (addr_q[1] == $past(nxt_dst) && len_q == $past(nxt_len)));
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
    import dma_chan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blk_done,
    input  logic                param_copy,
    input  logic                auto_mode,
    input  logic                len_wr,
    input  logic                clr_wr,
    input  logic [STATUS_W-1:0] clr_data,
    input  logic                chan_active,
    output logic                vld_q,
    output logic [STATUS_W-1:0] status_byte
);
    logic [FLAG_N-1:0] flag_q, set_v, hwclr_v, swclr_v;

    function automatic int flag_pos(input int idx);
        return (idx == 2) ? BIT_VLD : idx;
    endfunction

    assign set_v[0]   = blk_done;
    assign set_v[1]   = blk_done && (auto_mode ? flag_q[0] : !flag_q[2]);
    assign set_v[2]   = len_wr;
    assign hwclr_v[0] = 1'b0;
    assign hwclr_v[1] = 1'b0;
    assign hwclr_v[2] = param_copy;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_clr
        assign swclr_v[g] = clr_wr && clr_data[flag_pos(g)];
    end

    // set wins over any clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= set_v | (flag_q & ~(hwclr_v | swclr_v));
    end

    assign vld_q = flag_q[2];
    assign status_byte = {4'b0000, flag_q[2], chan_active, flag_q[1], flag_q[0]};

    p_tc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> status_byte[BIT_TC]);

    p_w1c_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[BIT_TC] && !blk_done) |=> !status_byte[BIT_TC]);

    p_w0_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !clr_data[BIT_OVR] && status_byte[BIT_OVR]) |=> status_byte[BIT_OVR]);

    p_vld_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_wr |=> status_byte[BIT_VLD]);

    p_ovr_dbl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !auto_mode && !status_byte[BIT_VLD]) |=> status_byte[BIT_OVR]);

    p_ovr_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && auto_mode && status_byte[BIT_TC]) |=> status_byte[BIT_OVR]);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && clr_wr && clr_data[BIT_TC]) |=> status_byte[BIT_TC]);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         xfer_strobe,
    output logic         chan_active,
    output logic         blk_done
);
    logic [CTRL_W-1:0]   ctrl_q;
    logic [W-1:0]        nxt_src, nxt_dst, nxt_len;
    logic [W-1:0]        cur_src, cur_dst, cur_len;
    logic [STATUS_W-1:0] status_byte;
    logic                vld_q, param_copy, len_wr, clr_wr;

    assign len_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_LEN_NEXT);
    assign clr_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            nxt_src <= '0;
            nxt_dst <= '0;
            nxt_len <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CTRL:     ctrl_q  <= wr_data[CTRL_W-1:0];
                SEL_SRC_NEXT: nxt_src <= wr_data;
                SEL_DST_NEXT: nxt_dst <= wr_data;
                SEL_LEN_NEXT: nxt_len <= wr_data;
                default:      ;
            endcase
        end
    end

    dma_chan_seq #(.W(W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctrl_q[0]),
        .auto_mode   (ctrl_q[1]),
        .xfer_strobe (xfer_strobe),
        .vld_q       (vld_q),
        .src_step    (step_code_e'(ctrl_q[3:2])),
        .dst_step    (step_code_e'(ctrl_q[5:4])),
        .nxt_src     (nxt_src),
        .nxt_dst     (nxt_dst),
        .nxt_len     (nxt_len),
        .cur_src     (cur_src),
        .cur_dst     (cur_dst),
        .cur_len     (cur_len),
        .blk_done    (blk_done),
        .param_copy  (param_copy),
        .chan_active (chan_active)
    );

    dma_flag_bank u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_done    (blk_done),
        .param_copy  (param_copy),
        .auto_mode   (ctrl_q[1]),
        .len_wr      (len_wr),
        .clr_wr      (clr_wr),
        .clr_data    (wr_data[STATUS_W-1:0]),
        .chan_active (chan_active),
        .vld_q       (vld_q),
        .status_byte (status_byte)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_CTRL:     rd_data = W'(ctrl_q);
            SEL_SRC_NEXT: rd_data = nxt_src;
            SEL_DST_NEXT: rd_data = nxt_dst;
            SEL_LEN_NEXT: rd_data = nxt_len;
            SEL_STATUS:   rd_data = W'(status_byte);
            SEL_SRC_CUR:  rd_data = cur_src;
            SEL_DST_CUR:  rd_data = cur_dst;
            SEL_LEN_CUR:  rd_data = cur_len;
        endcase
    end

    p_chac_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[BIT_CHAC] == chan_active);
endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_sel = '0;
    logic [W-1:0] rd_data;
    logic         xfer_strobe = 1'b0;
    logic         chan_active, blk_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_chan_engine #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_strobe(xfer_strobe),
        .chan_active(chan_active), .blk_done(blk_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sel, output int val);
        rd_sel = 3'(sel);
        #1;
        val = int'(rd_data);
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            @(negedge clk);
            xfer_strobe = 1'b1;
            @(negedge clk);
            xfer_strobe = 1'b0;
        end
    endtask

    function automatic int step_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return -1;
            default: return -2;
        endcase
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish");
        summary();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 8; s++) begin
            rd(s, v);
            check("R1", "register after reset", v, 0);
        end
        check("R1", "chan_active after reset", int'(chan_active), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 / R8 start
        wr(0, 8'h01);
        wr(1, 10);
        wr(2, 20);
        wr(3, 4);
        rd(4, v); check("R7", "status after len write", v, 8'h08);
        @(negedge clk);
        rd(7, v); check("R8", "count after start", v, 4);
        rd(5, v); check("R8", "src after start", v, 10);
        rd(4, v); check("R8", "status after start", v, 8'h04);
        check("R4", "chan_active running", int'(chan_active), 1);

        // R4 / R6 writes to CHAC and upper bits ignored
        wr(4, 8'hFF);
        rd(4, v); check("R4", "status after writing ones", v, 8'h04);

        // R3 strobes ignored when disabled
        wr(0, 8'h00);
        rd(4, v); check("R4", "status with enable low", v, 8'h00);
        pulse(2);
        rd(7, v); check("R3", "count while disabled", v, 4);
        rd(5, v); check("R3", "src while disabled", v, 10);
        wr(0, 8'h01);
        pulse(1);
        rd(7, v); check("R3", "count after one beat", v, 3);
        rd(5, v); check("R2", "src after +1", v, 11);
        rd(6, v); check("R2", "dst after +1", v, 21);

        // R9 double-buffered reload with valid
        wr(1, 100);
        wr(2, 200);
        wr(3, 2);
        rd(4, v); check("R7", "status with pending params", v, 8'h0C);
        pulse(3);
        rd(7, v); check("R9", "count after reload", v, 2);
        rd(5, v); check("R9", "src after reload", v, 100);
        rd(6, v); check("R9", "dst after reload", v, 200);
        rd(4, v); check("R5", "status after reload", v, 8'h05);

        // R6 write zero keeps, write one clears
        wr(4, 8'h00);
        rd(4, v); check("R6", "status after writing zero", v, 8'h05);
        wr(4, 8'h01);
        rd(4, v); check("R6", "status after clearing TC", v, 8'h04);

        // R6 VLD cleared by software, then R9 overrun
        wr(3, 5);
        rd(4, v); check("R7", "vld set again", v, 8'h0C);
        wr(4, 8'h08);
        rd(4, v); check("R6", "vld cleared", v, 8'h04);
        pulse(2);
        rd(4, v); check("R9", "overrun without valid", v, 8'h03);
        rd(7, v); check("R9", "count finished", v, 0);
        rd(5, v); check("R9", "src stepped at finish", v, 102);
        check("R4", "chan_active idle", int'(chan_active), 0);

        // R8 no start without valid
        repeat (3) @(negedge clk);
        rd(7, v); check("R8", "idle stays idle", v, 0);

        // R11 set wins over clear
        wr(4, 8'hFF);
        wr(1, 50);
        wr(2, 60);
        wr(3, 1);
        @(negedge clk);
        rd(7, v); check("R8", "single-beat block loaded", v, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h03; xfer_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; xfer_strobe = 1'b0;
        rd(4, v); check("R11", "set beats clear", v, 8'h03);

        // R10 auto-initialize, src +2, dst -2
        wr(4, 8'hFF);
        wr(0, 8'h37);
        wr(1, 30);
        wr(2, 40);
        wr(3, 2);
        @(negedge clk);
        pulse(2);
        rd(7, v); check("R10", "auto reload count", v, 2);
        rd(5, v); check("R10", "auto reload src", v, 30);
        rd(4, v); check("R10", "auto first finish", v, 8'h05);
        pulse(1);
        rd(5, v); check("R2", "src after +2", v, 32);
        rd(6, v); check("R2", "dst after -2", v, 38);
        pulse(1);
        rd(4, v); check("R10", "auto overrun with TC held", v, 8'h07);
        wr(4, 8'h03);
        pulse(2);
        rd(4, v); check("R10", "auto no overrun after clear", v, 8'h05);

        // leave auto mode and let the last block drain
        wr(0, 8'h01);
        pulse(2);
        wr(4, 8'hFF);
        rd(4, v); check("R6", "drained and cleared", v, 8'h00);

        // R2 sweep: every start address, every step pair, wraps included
        for (int code = 0; code < 16; code++) begin
            for (int s = 0; s < 256; s++) begin
                int sc, dc, es, ed;
                sc = code & 3;
                dc = code >> 2;
                wr(0, (dc << 4) | (sc << 2) | 1);
                wr(1, s);
                wr(2, 255 - s);
                wr(3, 3);
                @(negedge clk);
                pulse(3);
                es = (s + 3 * step_of(sc)) & 255;
                ed = (255 - s + 3 * step_of(dc)) & 255;
                rd(5, v); check("R2", "sweep src", v, es);
                rd(6, v); check("R2", "sweep dst", v, ed);
                rd(7, v); check("R3", "sweep count", v, 0);
                rd(4, v); check("R5", "sweep status", v, 8'h03);
                wr(4, 8'hFF);
            end
        end

        summary();
    end
endmodule